// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Qualification

This block is the digital heart of a speed loop for a spindle motor. It compares the rising edges of a reference tick with the falling edges of a conditioned tachometer pulse train and turns the time between them into a three-state correction drive. The drive has three states: `pump_up` (the motor lags and must speed up), `pump_dn` (the motor leads and must slow down), or both low (idle, a high-impedance error output in the analog domain). A downstream error amplifier and loop filter, which are not part of this block, integrate these pulses.

Each comparison ends when the second of the two edges arrives, and the length of its correction pulse is measured in clock cycles. A run of in-window comparisons qualifies lock, which is reported on an active-low open-drain-style enable `lock_n`. A shorter run of out-of-window comparisons withdraws lock. The tachometer input is resynchronised and also passed back out as a speed-monitor pulse. An active-high stop input (which is also the state of an unconnected pin) forces the drive idle, withdraws lock and clears all detector and qualification state.

Top module: `pfd_lock_core`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, the next cycle shows `pump_up`=0, `pump_dn`=0, `lock_n`=1 and `spd_mon`=1.
- R2: A rising edge on `ref_tick` with no down pulse pending sets `pump_up` two clock edges later. `pump_up` stays high until a tachometer falling edge closes it. When `fg_in` falls d cycles after `ref_tick` rises, `pump_up` is high for d+1 cycles.
- R3: A falling edge on `fg_in` with no up pulse pending sets `pump_dn` three clock edges later. A `ref_tick` rise that comes d>=2 cycles after the fall gives a `pump_dn` pulse of d-1 cycles. A rise 1 cycle after the fall meets it at the detector, and neither output pulses.
- R4: `pump_up` and `pump_dn` are never high together, and neither one goes directly into the other in the next cycle.
- R5: A comparison is in-window when its pulse width is not greater than `win_lim` (a width of zero counts as in-window). `lock_n` goes low on the clock edge that closes the 8th consecutive in-window comparison, and not earlier.
- R6: While locked, `lock_n` returns high on the edge that closes the 2nd consecutive out-of-window comparison. An in-window comparison between two out-of-window comparisons restarts that count.
- R7: A second reference rise while `pump_up` is already high (or a second tachometer fall while `pump_dn` is high) is a cycle slip. The pulse stays high, and the slip counts as an out-of-window comparison.
- R8: `stop_req` high at a clock edge clears `pump_up`, `pump_dn`, the lock flag and both run counts by the next cycle. While it stays high, reference and tachometer edges raise no pulse, and the in-window run begins again from zero afterwards.
- R9: `spd_mon` equals `fg_in` as it was two clock edges earlier, whether the block is stopped or running.
- R10: `lock_n` changes only on an edge that closes a comparison or a slip, or after `stop_req` or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_tick | input | 1 | Reference tick, compared on its rising edge |
| fg_in | input | 1 | Conditioned tachometer pulse, compared on its falling edge, asynchronous |
| stop_req | input | 1 | High (or open) stops the loop; low runs it |
| win_lim | input | WIN_W (8) | Largest pulse width, in cycles, that still counts as in-window |
| pump_up | output | 1 | Speed-up correction pulse |
| pump_dn | output | 1 | Slow-down correction pulse |
| lock_n | output | 1 | Low while phase lock is qualified |
| spd_mon | output | 1 | Resynchronised copy of `fg_in` |

## Verification
A reference rise shows on `pump_up` two edges later, because two registers detect the edge. A tachometer fall shows on `pump_dn` three edges later, because the signal passes through two synchroniser stages and one edge register. A pulse is cleared, and `lock_n` updated, on the edge where the opposing edge reaches the detector. `stop_req` and `rst_n` act on the very next edge, and `spd_mon` trails `fg_in` by two edges. The bench drives inputs and samples outputs on falling clock edges. For pulse widths, it counts high samples over a window long enough for the slowest path, and it reads `lock_n` only after each comparison has fully settled.

// File: rtl/pfd_lock_pkg.sv
// Shared defaults and the comparison-event type for the phase detector.
// Assumes: all users import this package before their port lists.
package pfd_lock_pkg;

    parameter int unsigned WIN_W_DEF    = 8;
    parameter int unsigned LOCK_RUN_DEF = 8;
    parameter int unsigned DROP_RUN_DEF = 2;
    parameter int unsigned SYNC_DEF     = 2;

    // One comparison outcome per cycle: the pair closed, or a cycle slipped.
    typedef struct packed {
        logic clr;
        logic slip;
    } cmp_ev_t;

endpackage

// File: rtl/pfd_edge_front.sv
// Edge front: resynchronises the tachometer input, registers the reference
// and produces single-cycle edge strobes from registered copies only.
// Assumes: ref_tick is already in the clk domain; fg_in is asynchronous.
module pfd_edge_front #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_tick,
    input  logic fg_in,
    output logic ref_rise,
    output logic fg_fall,
    output logic fg_clean
);

    localparam int unsigned FG_LEN = SYNC_STAGES + 1;

    logic [1:0]        ref_pipe;
    logic [FG_LEN-1:0] fg_pipe;

    // Reference history: two registered samples for rise detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_pipe <= 2'b00;
        end else begin
            ref_pipe <= {ref_pipe[0], ref_tick};
        end
    end

    // Tachometer synchroniser plus one history stage; idles high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fg_pipe <= '1;
        end else begin
            fg_pipe <= {fg_pipe[FG_LEN-2:0], fg_in};
        end
    end

    // Edge strobes from the registered copies.
    always_comb begin
        ref_rise = ref_pipe[0] & ~ref_pipe[1];
        fg_fall  = fg_pipe[FG_LEN-1] & ~fg_pipe[FG_LEN-2];
        fg_clean = fg_pipe[FG_LEN-2];
    end

endmodule

// File: rtl/pfd_detector.sv
// Two-flip-flop phase-frequency detector. The reference edge sets the up
// flag and the tachometer edge sets the down flag; the cycle in which both
// would be set clears both, so the outputs are never high together.
// Assumes: edge strobes last one cycle; halt is synchronous.
module pfd_detector
    import pfd_lock_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    halt,
    input  logic    ref_rise,
    input  logic    fg_fall,
    output logic    up_q,
    output logic    dn_q,
    output cmp_ev_t ev
);

    logic up_set;
    logic dn_set;

    // Closing and slip decisions for this cycle.
    always_comb begin
        up_set  = up_q | ref_rise;
        dn_set  = dn_q | fg_fall;
        ev.clr  = up_set & dn_set;
        ev.slip = ~ev.clr & ((ref_rise & up_q) | (fg_fall & dn_q));
    end

    // Detector flags: set by edges, cleared together on a closing pair.
    always_ff @(posedge clk) begin
        if (!rst_n || halt) begin
            up_q <= 1'b0;
            dn_q <= 1'b0;
        end else if (ev.clr) begin
            up_q <= 1'b0;
            dn_q <= 1'b0;
        end else begin
            up_q <= up_set;
            dn_q <= dn_set;
        end
    end

endmodule

// File: rtl/pfd_lock_judge.sv
// Lock qualifier: measures each correction pulse in cycles, grades every
// comparison against the window and keeps runs of good and bad results.
// Assumes: ev arrives in the cycle the detector closes or slips; the width
// counter saturates so a stuck pulse still grades as out of window.
module pfd_lock_judge
    import pfd_lock_pkg::*;
#(
    parameter int unsigned WIN_W    = WIN_W_DEF,
    parameter int unsigned LOCK_RUN = LOCK_RUN_DEF,
    parameter int unsigned DROP_RUN = DROP_RUN_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt,
    input  logic             pending,
    input  cmp_ev_t          ev,
    input  logic [WIN_W-1:0] win_lim,
    output logic             locked
);

    localparam int unsigned GW = $clog2(LOCK_RUN + 1);
    localparam int unsigned BW = $clog2(DROP_RUN + 1);
    localparam logic [GW-1:0]    GOOD_LAST = GW'(LOCK_RUN - 1);
    localparam logic [BW-1:0]    BAD_LAST  = BW'(DROP_RUN - 1);
    localparam logic [WIN_W-1:0] WID_MAX   = '1;

    logic [WIN_W-1:0] wid_cnt;
    logic [WIN_W:0]   width_now;
    logic             in_win;
    logic             ev_any;
    logic [GW-1:0]    good_run;
    logic [BW-1:0]    bad_run;

    // Width of the pulse that would close in this cycle, and its grade.
    always_comb begin
        width_now = pending ? ({1'b0, wid_cnt} + 1'b1) : '0;
        ev_any    = ev.clr | ev.slip;
        in_win    = ev.clr && (width_now <= {1'b0, win_lim});
    end

    // Pulse-width counter: runs while a flag stays high, else restarts.
    always_ff @(posedge clk) begin
        if (!rst_n || halt) begin
            wid_cnt <= '0;
        end else if (pending && !ev.clr) begin
            wid_cnt <= (wid_cnt == WID_MAX) ? wid_cnt : wid_cnt + 1'b1;
        end else begin
            wid_cnt <= '0;
        end
    end

    // Run counters and lock flag, advanced once per graded comparison.
    always_ff @(posedge clk) begin
        if (!rst_n || halt) begin
            good_run <= '0;
            bad_run  <= '0;
            locked   <= 1'b0;
        end else if (ev_any) begin
            if (in_win) begin
                bad_run <= '0;
                if (!locked) begin
                    if (good_run == GOOD_LAST) begin
                        good_run <= '0;
                        locked   <= 1'b1;
                    end else begin
                        good_run <= good_run + 1'b1;
                    end
                end
            end else begin
                good_run <= '0;
                if (locked) begin
                    if (bad_run == BAD_LAST) begin
                        bad_run <= '0;
                        locked  <= 1'b0;
                    end else begin
                        bad_run <= bad_run + 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/pfd_lock_core.sv
// Top of the phase comparator: edge front, detector and lock qualifier.
// Assumes: stop_req is synchronous to clk and high means stopped.
module pfd_lock_core
    import pfd_lock_pkg::*;
#(
    parameter int unsigned WIN_W       = WIN_W_DEF,
    parameter int unsigned LOCK_RUN    = LOCK_RUN_DEF,
    parameter int unsigned DROP_RUN    = DROP_RUN_DEF,
    parameter int unsigned SYNC_STAGES = SYNC_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  logic             fg_in,
    input  logic             stop_req,
    input  logic [WIN_W-1:0] win_lim,
    output logic             pump_up,
    output logic             pump_dn,
    output logic             lock_n,
    output logic             spd_mon
);

    logic    ref_rise;
    logic    fg_fall;
    logic    fg_clean;
    logic    up_q;
    logic    dn_q;
    logic    locked;
    logic    cmp_any;
    cmp_ev_t ev;

    pfd_edge_front #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_front (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .fg_in    (fg_in),
        .ref_rise (ref_rise),
        .fg_fall  (fg_fall),
        .fg_clean (fg_clean)
    );

    pfd_detector u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .halt     (stop_req),
        .ref_rise (ref_rise),
        .fg_fall  (fg_fall),
        .up_q     (up_q),
        .dn_q     (dn_q),
        .ev       (ev)
    );

    pfd_lock_judge #(
        .WIN_W    (WIN_W),
        .LOCK_RUN (LOCK_RUN),
        .DROP_RUN (DROP_RUN)
    ) u_judge (
        .clk     (clk),
        .rst_n   (rst_n),
        .halt    (stop_req),
        .pending (up_q | dn_q),
        .ev      (ev),
        .win_lim (win_lim),
        .locked  (locked)
    );

    // Output mapping: lock enable is active low, monitor follows FG.
    always_comb begin
        pump_up = up_q;
        pump_dn = dn_q;
        lock_n  = ~locked;
        spd_mon = fg_clean;
        cmp_any = ev.clr | ev.slip;
    end

endmodule

// File: rtl/pfd_lock_chk.sv
// Checker for pfd_lock_core, attached by bind. Watches ports and the
// detector's event strobe against the lock flag.
module pfd_lock_chk (
    input logic clk,
    input logic rst_n,
    input logic stop_req,
    input logic fg_in,
    input logic pump_up,
    input logic pump_dn,
    input logic lock_n,
    input logic spd_mon,
    input logic cmp_any
);

    logic [1:0] since_rst;

    // Counts edges since reset so two-deep history is only used when valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= 2'd0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    // R1
    rst_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!pump_up && !pump_dn && lock_n && spd_mon));

    // R4
    pump_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pump_up && pump_dn));

    // R4
    up_no_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pump_up |=> !pump_dn);

    // R4
    dn_no_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pump_dn |=> !pump_up);

    // R8
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |=> (!pump_up && !pump_dn && lock_n));

    // R10
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_any && !stop_req) |=> $stable(lock_n));

    // R9
    spd_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2) |-> (spd_mon == $past(fg_in, 2)));

endmodule

bind pfd_lock_core pfd_lock_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .stop_req (stop_req),
    .fg_in    (fg_in),
    .pump_up  (pump_up),
    .pump_dn  (pump_dn),
    .lock_n   (lock_n),
    .spd_mon  (spd_mon),
    .cmp_any  (cmp_any)
);

// File: tb/pfd_lock_core_bench.sv
// Bench for pfd_lock_core: a vector table of pulse widths, then directed
// lock, slip, stop and reset cases. Inputs change and outputs are read on
// falling clock edges.
module pfd_lock_core_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_tick = 1'b0;
    logic       fg_in = 1'b1;
    logic       stop_req = 1'b0;
    logic [7:0] win_lim = 8'd8;
    logic       pump_up;
    logic       pump_dn;
    logic       lock_n;
    logic       spd_mon;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // Columns: reference first (1) or FG first (0), gap d, up width, down width.
    localparam int VEC [6][4] = '{
        '{1, 0, 1, 0},
        '{1, 3, 4, 0},
        '{1, 6, 7, 0},
        '{0, 1, 0, 0},
        '{0, 2, 0, 1},
        '{0, 5, 0, 4}
    };

    always #5 clk = ~clk;

    pfd_lock_core u_pfd_lock_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .fg_in    (fg_in),
        .stop_req (stop_req),
        .win_lim  (win_lim),
        .pump_up  (pump_up),
        .pump_dn  (pump_dn),
        .lock_n   (lock_n),
        .spd_mon  (spd_mon)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One comparison: first edge at step 0, the other d steps later.
    task automatic run_cmp(input int ref_first, input int d,
                           output int wu, output int wd, output int wb);
        wu = 0; wd = 0; wb = 0;
        for (int i = 0; i < d + 12; i++) begin
            @(negedge clk);
            wu += int'(pump_up);
            wd += int'(pump_dn);
            wb += int'(pump_up && pump_dn);
            if (i == 0) begin
                if (ref_first != 0) ref_tick = 1'b1; else fg_in = 1'b0;
            end
            if (i == d) begin
                if (ref_first != 0) fg_in = 1'b0; else ref_tick = 1'b1;
            end
        end
        @(negedge clk);
        ref_tick = 1'b0;
        fg_in = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic runs(input int n, input int d);
        int wu, wd, wb;
        for (int k = 0; k < n; k++) run_cmp(1, d, wu, wd, wb);
    endtask

    task automatic ref_pulse();
        @(negedge clk);
        ref_tick = 1'b1;
        repeat (3) @(negedge clk);
        ref_tick = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int wu, wd, wb;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 pump_up", int'(pump_up), 0);
        check("R1 pump_dn", int'(pump_dn), 0);
        check("R1 lock_n", int'(lock_n), 1);
        check("R1 spd_mon", int'(spd_mon), 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R2 R3 R4: pulse widths from the table
        for (int v = 0; v < 6; v++) begin
            run_cmp(VEC[v][0], VEC[v][1], wu, wd, wb);
            check(VEC[v][0] != 0 ? "R2 up width" : "R3 up width", wu, VEC[v][2]);
            check(VEC[v][0] != 0 ? "R2 dn width" : "R3 dn width", wd, VEC[v][3]);
            check("R4 overlap", wb, 0);
        end

        // R5: six in-window so far, lock after the eighth
        runs(1, 1);
        check("R5 after 7 good", int'(lock_n), 1);
        runs(1, 1);
        check("R5 after 8 good", int'(lock_n), 0);

        // R6: window of 2 cycles; width 3 is out, width 2 is in
        win_lim = 8'd2;
        runs(1, 2);
        check("R6 one bad", int'(lock_n), 0);
        runs(1, 1);
        runs(1, 2);
        check("R6 bad good bad", int'(lock_n), 0);
        runs(1, 2);
        check("R6 two bad", int'(lock_n), 1);

        // R5: boundary width equal to the window
        runs(7, 1);
        check("R5 boundary 7", int'(lock_n), 1);
        runs(1, 1);
        check("R5 boundary 8", int'(lock_n), 0);

        // R7: repeated reference edges without FG
        ref_pulse();
        check("R7 up pending", int'(pump_up), 1);
        check("R7 lock after set", int'(lock_n), 0);
        ref_pulse();
        check("R7 one slip", int'(lock_n), 0);
        check("R7 up held", int'(pump_up), 1);
        ref_pulse();
        check("R7 two slips", int'(lock_n), 1);
        @(negedge clk);
        fg_in = 1'b0;
        repeat (5) @(negedge clk);
        fg_in = 1'b1;
        repeat (3) @(negedge clk);
        check("R7 closed", int'(pump_up), 0);

        // R8: stop clears lock, blocks edges, restarts the run
        runs(8, 1);
        check("R8 locked before stop", int'(lock_n), 0);
        stop_req = 1'b1;
        @(negedge clk);
        check("R8 lock dropped", int'(lock_n), 1);
        ref_pulse();
        check("R8 ref ignored", int'(pump_up), 0);
        // R9: monitor during stop, two edges behind
        fg_in = 1'b0;
        @(negedge clk);
        check("R9 one edge", int'(spd_mon), 1);
        @(negedge clk);
        check("R9 two edges", int'(spd_mon), 0);
        check("R8 fg ignored", int'(pump_dn), 0);
        fg_in = 1'b1;
        repeat (3) @(negedge clk);
        check("R9 back high", int'(spd_mon), 1);
        stop_req = 1'b0;
        repeat (2) @(negedge clk);
        runs(7, 1);
        check("R8 run restarted", int'(lock_n), 1);
        runs(1, 1);
        check("R8 relock", int'(lock_n), 0);
        @(negedge clk);
        ref_tick = 1'b1;
        repeat (3) @(negedge clk);
        check("R8 up before stop", int'(pump_up), 1);
        stop_req = 1'b1;
        @(negedge clk);
        check("R8 up cleared", int'(pump_up), 0);
        check("R8 lock cleared", int'(lock_n), 1);
        ref_tick = 1'b0;
        @(negedge clk);
        stop_req = 1'b0;
        repeat (2) @(negedge clk);

        // R1: reset while locked
        runs(8, 1);
        check("R1 locked before reset", int'(lock_n), 0);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset drops lock", int'(lock_n), 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule